// File: doc/BRIEF.md
# Slow Infrared Baud Rate Generator

This block produces the timing strobes for the slow asynchronous infrared link. It runs from a fixed 48 MHz clock. A fixed divide-by-26 prescaler feeds a 6-bit reload counter, and that counter divides by the programmed count plus one. The result is a one-cycle sample strobe at sixteen times the bit rate. A second strobe fires once every sixteen sample strobes and marks the bit boundaries. The bit rate is 48 MHz / 26 / 16 / (count + 1). The reset count of 11 gives 9600 bit/s.

The block also holds the 2-bit receive-timeout select. The timeout detector elsewhere in the design reads it. Count writes take effect only while the link runs in its slow mode. A count written mid-period is picked up at the next reload of the counter, so no period is ever cut short.

Top module: `irsl_baud_gen`

## Requirements
- R1: After reset, `baud_count` reads 11, `rto_sel` reads 0, and neither strobe is asserted.
- R2: With a fixed count N, consecutive `sample_tick` pulses are exactly 26 × (N + 1) clock cycles apart (312 cycles for N = 11).
- R3: `sample_tick` is high for exactly one clock cycle per pulse.
- R4: `bit_tick` is a one-cycle pulse asserted in the cycle after every sixteenth `sample_tick`. Consecutive `bit_tick` pulses are 16 × 26 × (N + 1) cycles apart, with exactly 16 sample ticks between them.
- R5: A count written between two sample ticks leaves the period in progress unchanged. The new count governs the next period and every period after it.
- R6: A count write (`cnt_wr_en` high, value on `cnt_wr_data[5:0]`) updates `baud_count` on the next edge only while `slow_mode` is 1. While `slow_mode` is 0, the write has no effect on `baud_count` or on the tick period.
- R7: A timeout write (`rto_wr_en` high) of 0, 1 or 2 on `rto_wr_data[1:0]` updates `rto_sel` on the next edge. A write of 3 is ignored and the previous value is kept.
- R8: The extreme counts work: N = 0 gives a 26-cycle sample period and N = 63 gives a 1664-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_mode | input | 1 | 1 while the link is in its slow asynchronous mode; gates count writes |
| cnt_wr_en | input | 1 | Count write strobe |
| cnt_wr_data | input | 6 | New baud count N |
| rto_wr_en | input | 1 | Timeout-select write strobe |
| rto_wr_data | input | 2 | New timeout select (0 to 2 legal) |
| baud_count | output | 6 | Count currently held |
| rto_sel | output | 2 | Timeout select currently held |
| sample_tick | output | 1 | One-cycle strobe at 16 × bit rate |
| bit_tick | output | 1 | One-cycle strobe at the bit rate |

## Verification
The bench builds the block with its default parameters: a prescale of 26, a 6-bit count, 16× oversampling and a reset count of 11. These are the real rate values, so the measured intervals (26, 312, 1664 and 4992 cycles) are the actual periods the link relies on. Both ends of the count range are covered. The largest bit period stays short enough that several periods fit in one run. Count changes are written right after a sample tick, so the period in progress and the period that follows can each be measured.

// File: rtl/irsl_pkg.sv
package irsl_pkg;
    localparam int unsigned CNT_W      = 6;
    localparam int unsigned RTO_W      = 2;
    localparam int unsigned PRESCALE   = 26;
    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned RST_COUNT  = 11;
    localparam int unsigned RTO_MAX    = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [RTO_W-1:0] rto;
    } cfg_t;
endpackage

// File: rtl/irsl_prescale.sv
module irsl_prescale #(
    parameter int unsigned DIV = 26
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    assign tick_o = (pre_q == LAST);

    always_comb begin
        pre_d = tick_o ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2: the prescale count wraps to zero right after its terminal value
    a_r2_prescale_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (pre_q == '0));
endmodule

// File: rtl/irsl_reload.sv
module irsl_reload #(
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned RST_COUNT = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             fire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic             fire;
    } rl_t;

    rl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (step_i) begin
            if (st_q.div == '0) begin
                st_d.div  = load_i;
                st_d.fire = 1'b1;
            end else begin
                st_d.div = st_q.div - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{div: CNT_W'(RST_COUNT), fire: 1'b0};
        else        st_q <= st_d;
    end

    assign fire_o = st_q.fire;

    // R3: sample strobe never lasts two cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    // R5: a strobe follows only a prescale step that found the counter empty
    a_r5_fire_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(step_i));
endmodule

// File: rtl/irsl_oversample.sv
module irsl_oversample #(
    parameter int unsigned OS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_i,
    output logic bit_o
);
    localparam int unsigned OW = (OS > 1) ? $clog2(OS) : 1;
    localparam logic [OW-1:0] LAST = OW'(OS - 1);

    typedef struct packed {
        logic [OW-1:0] phase;
        logic          bit_stb;
    } os_t;

    os_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.bit_stb = 1'b0;
        if (samp_i) begin
            if (st_q.phase == LAST) begin
                st_d.phase   = '0;
                st_d.bit_stb = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.bit_stb;

    // R4: a bit strobe comes one cycle after a sample strobe
    a_r4_bit_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        bit_o |-> $past(samp_i));
endmodule

// File: rtl/irsl_baud_gen.sv
module irsl_baud_gen
    import irsl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_mode,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             rto_wr_en,
    input  logic [RTO_W-1:0] rto_wr_data,
    output logic [CNT_W-1:0] baud_count,
    output logic [RTO_W-1:0] rto_sel,
    output logic             sample_tick,
    output logic             bit_tick
);
    cfg_t cfg_d, cfg_q;
    logic pre_tick;

    always_comb begin
        cfg_d = cfg_q;
        if (cnt_wr_en && slow_mode)
            cfg_d.cnt = cnt_wr_data;
        if (rto_wr_en && (rto_wr_data <= RTO_W'(RTO_MAX)))
            cfg_d.rto = rto_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{cnt: CNT_W'(RST_COUNT), rto: '0};
        else        cfg_q <= cfg_d;
    end

    assign baud_count = cfg_q.cnt;
    assign rto_sel    = cfg_q.rto;

    irsl_prescale #(.DIV(PRESCALE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (pre_tick)
    );

    irsl_reload #(.CNT_W(CNT_W), .RST_COUNT(RST_COUNT)) u_reload (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (pre_tick),
        .load_i (cfg_q.cnt),
        .fire_o (sample_tick)
    );

    irsl_oversample #(.OS(OVERSAMPLE)) u_os (
        .clk    (clk),
        .rst_n  (rst_n),
        .samp_i (sample_tick),
        .bit_o  (bit_tick)
    );

    // R6: count writes outside the slow mode leave the count untouched
    a_r6_cnt_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr_en && !slow_mode) |=> $stable(baud_count));
    // R7: the illegal timeout code never lands
    a_r7_rto_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (rto_wr_en && rto_wr_data == 2'd3) |=> $stable(rto_sel));
    // R7: the held timeout select is always a legal code
    a_r7_rto_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rto_sel != 2'd3);
endmodule

// File: tb/irsl_baud_gen_bench.sv
module irsl_baud_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_mode = 1'b1;
    logic       cnt_wr_en = 1'b0;
    logic [5:0] cnt_wr_data = '0;
    logic       rto_wr_en = 1'b0;
    logic [1:0] rto_wr_data = '0;
    logic [5:0] baud_count;
    logic [1:0] rto_sel;
    logic       sample_tick;
    logic       bit_tick;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    int samp_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (sample_tick) samp_seen <= samp_seen + 1;

    irsl_baud_gen u_irsl_baud_gen (
        .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .rto_wr_en(rto_wr_en), .rto_wr_data(rto_wr_data),
        .baud_count(baud_count), .rto_sel(rto_sel),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_samp(output int t);
        do @(negedge clk); while (sample_tick !== 1'b1);
        t = cyc;
    endtask

    task automatic wait_bit(output int t);
        do @(negedge clk); while (bit_tick !== 1'b1);
        t = cyc;
    endtask

    task automatic write_cnt(input logic [5:0] v);
        cnt_wr_data = v; cnt_wr_en = 1'b1;
        @(negedge clk);
        cnt_wr_en = 1'b0;
    endtask

    task automatic write_rto(input logic [1:0] v);
        rto_wr_data = v; rto_wr_en = 1'b1;
        @(negedge clk);
        rto_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 count", baud_count, 11);
        check("R1 rto", rto_sel, 0);
        check("R1 sample idle", sample_tick, 0);
        check("R1 bit idle", bit_tick, 0);
    endtask

    task automatic t_period_default();
        int a, b;
        wait_samp(a);
        @(negedge clk);
        check("R3 one cycle", sample_tick, 0);
        wait_samp(b);
        check("R2 period N=11", b - a, 312);
    endtask

    task automatic t_bit();
        int a, b, sa;
        logic prev_samp;
        wait_bit(a);
        sa = samp_seen;
        wait_bit(b);
        check("R4 bit period", b - a, 4992);
        check("R4 samples per bit", samp_seen - sa, 16);
        do begin
            prev_samp = sample_tick;
            @(negedge clk);
        end while (bit_tick !== 1'b1);
        check("R4 sample precedes bit", prev_samp, 1);
        @(negedge clk);
        check("R4 bit one cycle", bit_tick, 0);
    endtask

    task automatic t_change(input logic [5:0] nv, input int old_p, input int new_p);
        int a, b, c;
        wait_samp(a);
        write_cnt(nv);
        check("R6 readback", baud_count, nv);
        wait_samp(b);
        check("R5 old period kept", b - a, old_p);
        wait_samp(c);
        check("R8 new period", c - b, new_p);
    endtask

    task automatic t_ignored();
        int a, b;
        slow_mode = 1'b0;
        wait_samp(a);
        write_cnt(6'd5);
        check("R6 ignored count", baud_count, 63);
        wait_samp(b);
        check("R6 period kept", b - a, 1664);
        wait_samp(a);
        check("R6 period still kept", a - b, 1664);
        slow_mode = 1'b1;
    endtask

    task automatic t_rto();
        write_rto(2'd2);
        check("R7 rto=2", rto_sel, 2);
        write_rto(2'd3);
        check("R7 rto 3 ignored", rto_sel, 2);
        write_rto(2'd1);
        check("R7 rto=1", rto_sel, 1);
        write_rto(2'd0);
        check("R7 rto=0", rto_sel, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_period_default();
                t_bit();
                t_change(6'd0, 312, 26);
                t_change(6'd63, 26, 1664);
                t_ignored();
                t_rto();
                t_change(6'd11, 1664, 312);
            end
            begin
                repeat (150000) @(posedge clk);
                nchk++; nerr++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule